// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock core. A free-running enable pulse from a slow reference (nominally 32.768 kHz) is divided down to a once-per-second tick. While counting is switched on, that tick advances a 32-bit seconds register. When an alarm is armed and the incremented count reaches the programmed alarm value, a sticky alarm event is raised. A sticky per-second event is raised on every increment. Each event has its own enable into a single interrupt line.

Software reaches the block through a minimal 32-bit write/read port. The write path is guarded in two ways. First, a key word written to the unlock register arms exactly one following register write. Second, every accepted write holds a ready bit low for a fixed number of cycles. This models the commit latency of a slow timekeeping domain. Writes made while locked or while not ready are ignored. A general-purpose scratch register lets firmware leave an "already initialised" marker. Reads are combinational from the address.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, seconds, alarm, scratch and all control fields are 0, the unlock register reads 0, the control register reads 0x80 (ready) and irq is 0.
- R2: A write of exactly 0x0000A55A to offset 0x3C while ready is high sets bit 31 of that register. A write of any other value clears it. A write to 0x3C while ready is low is ignored.
- R3: Writes to control (0x00), seconds (0x04), alarm (0x08) or scratch (0x34) take effect only when bit 31 of 0x3C is set and ready is high. Otherwise the target keeps its value.
- R4: An accepted register write clears the unlock bit, so a second write needs a new key.
- R5: Control bit 7 (ready, read-only) reads 0 for exactly BUSY_CYCLES clock cycles after an accepted write and then reads 1.
- R6: The scratch register stores and returns any 32-bit value.
- R7: With control bit 0 (run) set, every PRESCALE-th slow_en pulse increments the seconds register by one. With run clear, the seconds register does not change.
- R8: When control bit 2 (alarm arm) is set and a tick makes the seconds value equal to the alarm register, control bit 4 (alarm event) becomes 1.
- R9: Each increment sets control bit 6 (second event). On a control write, bits 5, 3, 2 and 0 take the written value. Bits 6 and 4 are cleared by writing 0 and kept by writing 1. A tick that sets an event bit in the same cycle wins over a clear.
- R10: irq equals (bit 6 AND bit 5) OR (bit 4 AND bit 3) of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle pulse per slow reference period |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Combined event interrupt |

## Verification
A table of write attempts is run. Each row is either preceded by the key or made locked, and each targets a different register. This separates a guard that ignores locked writes from one that always or never accepts them, and shows that the key is spent after one write. The counter is then fed pulse counts one short of a tick, exactly one tick, and ticks that land on the alarm value. This exposes off-by-one divider errors and alarm compares made against the old count. Control writes that mix 0s and 1s in the two event bits, with the interrupt enables on and off, tell write-0-to-clear apart from plain overwrite. They also show that each event feeds irq only through its own enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_SECONDS = 8'h04;
    localparam logic [7:0] OFS_ALARM   = 8'h08;
    localparam logic [7:0] OFS_SCRATCH = 8'h34;
    localparam logic [7:0] OFS_UNLOCK  = 8'h3C;

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_A55A;

    localparam int B_READY  = 7;
    localparam int B_EV_SEC = 6;
    localparam int B_IE_SEC = 5;
    localparam int B_EV_ALM = 4;
    localparam int B_IE_ALM = 3;
    localparam int B_ARM    = 2;
    localparam int B_RUN    = 0;

    typedef struct packed {
        logic [31:0] seconds;
        logic [31:0] alarm;
        logic [31:0] scratch;
        logic        ev_sec;
        logic        ie_sec;
        logic        ev_alm;
        logic        ie_alm;
        logic        arm;
        logic        run;
    } rtc_regs_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_en,
    output logic tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (slow_en) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run && slow_en)) else $error("tick without run"); // R7

endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
    import rtc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic        ready,
    output logic        unlocked,
    output logic        commit
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

    typedef struct packed {
        logic          unl;
        logic [BW-1:0] busy;
    } gate_t;

    gate_t g_d, g_q;
    logic  hits_reg;

    always_comb begin
        hits_reg = (addr == OFS_CTRL) || (addr == OFS_SECONDS) ||
                   (addr == OFS_ALARM) || (addr == OFS_SCRATCH);
        ready    = (g_q.busy == '0);
        unlocked = g_q.unl;
        commit   = wr && hits_reg && g_q.unl && ready;

        g_d = g_q;
        if (g_q.busy != '0) g_d.busy = g_q.busy - 1'b1;
        if (wr && (addr == OFS_UNLOCK) && ready) g_d.unl = (wdata == UNLOCK_KEY);
        if (commit) begin
            g_d.unl  = 1'b0;
            g_d.busy = BUSY_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    AST_RELOCK_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !unlocked) else $error("unlock survived a write"); // R4
    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !ready) else $error("ready high after write"); // R5
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.busy == BW'(1)) |=> ready) else $error("ready stuck low"); // R5
    AST_BUSY_UNLOCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !unlocked && wr && addr == OFS_UNLOCK) |=> !unlocked)
        else $error("unlock taken while busy"); // R2

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE    = 32768,
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_en,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    rtc_regs_t r_d, r_q;
    logic tick, ready, unlocked, commit;
    logic [31:0] sec_inc;
    logic alm_hit;
    logic [31:0] ctrl_view;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(r_q.run), .slow_en(slow_en), .tick(tick)
    );

    rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ready(ready), .unlocked(unlocked), .commit(commit)
    );

    always_comb begin
        sec_inc = r_q.seconds + 32'd1;
        alm_hit = tick && r_q.arm && (sec_inc == r_q.alarm);

        r_d = r_q;
        if (tick) begin
            r_d.seconds = sec_inc;
            r_d.ev_sec  = 1'b1;
        end
        if (alm_hit) r_d.ev_alm = 1'b1;

        if (commit) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    r_d.ie_sec = bus_wdata[B_IE_SEC];
                    r_d.ie_alm = bus_wdata[B_IE_ALM];
                    r_d.arm    = bus_wdata[B_ARM];
                    r_d.run    = bus_wdata[B_RUN];
                    r_d.ev_sec = (r_q.ev_sec & bus_wdata[B_EV_SEC]) | tick;
                    r_d.ev_alm = (r_q.ev_alm & bus_wdata[B_EV_ALM]) | alm_hit;
                end
                OFS_SECONDS: r_d.seconds = bus_wdata;
                OFS_ALARM:   r_d.alarm   = bus_wdata;
                OFS_SCRATCH: r_d.scratch = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[B_READY]  = ready;
        ctrl_view[B_EV_SEC] = r_q.ev_sec;
        ctrl_view[B_IE_SEC] = r_q.ie_sec;
        ctrl_view[B_EV_ALM] = r_q.ev_alm;
        ctrl_view[B_IE_ALM] = r_q.ie_alm;
        ctrl_view[B_ARM]    = r_q.arm;
        ctrl_view[B_RUN]    = r_q.run;
        case (bus_addr)
            OFS_CTRL:    bus_rdata = ctrl_view;
            OFS_SECONDS: bus_rdata = r_q.seconds;
            OFS_ALARM:   bus_rdata = r_q.alarm;
            OFS_SCRATCH: bus_rdata = r_q.scratch;
            OFS_UNLOCK:  bus_rdata = {unlocked, 31'd0};
            default:     bus_rdata = '0;
        endcase
        irq = (r_q.ev_sec & r_q.ie_sec) | (r_q.ev_alm & r_q.ie_alm);
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(commit && bus_addr == OFS_SECONDS)) |=> r_q.seconds == $past(r_q.seconds) + 32'd1)
        else $error("seconds did not step"); // R7
    AST_LOCKED_SCRATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && bus_addr == OFS_SCRATCH) |=> $stable(r_q.scratch))
        else $error("locked write landed"); // R3
    AST_ALARM_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ev_alm) |-> $past(tick)) else $error("alarm event without tick"); // R8
    AST_SEC_EVENT_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ev_sec) |-> $past(tick)) else $error("second event without tick"); // R9

endmodule

// File: tb/rtc_sec_core_tb.sv
module rtc_sec_core_tb;
    localparam int PRE  = 4;
    localparam int BUSY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_en = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_sec_core #(.PRESCALE(PRE), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {key first, offset, data, expected readback}
    localparam logic [72:0] VECS [6] = '{
        {1'b1, 8'h34, 32'h1234_5678, 32'h1234_5678},
        {1'b0, 8'h34, 32'hDEAD_BEEF, 32'h1234_5678},
        {1'b1, 8'h08, 32'h0000_0010, 32'h0000_0010},
        {1'b1, 8'h04, 32'h0000_000E, 32'h0000_000E},
        {1'b0, 8'h04, 32'h0000_0005, 32'h0000_000E},
        {1'b1, 8'h00, 32'h0000_002C, 32'h0000_00AC}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            slow_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slow_en = 1'b0;
        end
    endtask

    task automatic keyed_wr(input logic [7:0] a, input logic [31:0] d);
        wr(8'h3C, 32'h0000_A55A);
        wr(a, d);
        idle(BUSY);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h00, r); check("R1 ctrl", r, 32'h80);
        rd(8'h04, r); check("R1 seconds", r, 32'h0);
        rd(8'h34, r); check("R1 scratch", r, 32'h0);
        rd(8'h3C, r); check("R1 unlock", r, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R3 R4 R6 vector walk
        for (int i = 0; i < 6; i++) begin
            logic [72:0] v;
            v = VECS[i];
            if (v[72]) begin
                wr(8'h3C, 32'h0000_A55A);
                rd(8'h3C, r); check("R2 unlock set", r, 32'h8000_0000);
            end
            wr(v[71:64], v[63:32]);
            rd(8'h00, r);
            check("R5 ready after write", {31'd0, r[7]}, {31'd0, ~v[72]});
            idle(BUSY);
            rd(8'h3C, r); check("R4 relocked", r, 32'h0);
            rd(v[71:64], r); check("R3 R6 readback", r, v[31:0]);
        end

        // R5 exact busy window
        wr(8'h3C, 32'h0000_A55A);
        wr(8'h34, 32'hCAFE_F00D);
        for (int k = 0; k < BUSY; k++) begin
            rd(8'h00, r); check("R5 ready low", {31'd0, r[7]}, 32'd0);
            idle(1);
        end
        rd(8'h00, r); check("R5 ready back", {31'd0, r[7]}, 32'd1);

        // R2 unlock ignored while busy, wrong key
        wr(8'h3C, 32'h0000_A55A);
        wr(8'h34, 32'h0);
        wr(8'h3C, 32'h0000_A55A);
        idle(BUSY);
        rd(8'h3C, r); check("R2 busy unlock ignored", r, 32'h0);
        wr(8'h3C, 32'h0000_1234);
        rd(8'h3C, r); check("R2 wrong key", r, 32'h0);
        wr(8'h34, 32'h1111_1111);
        rd(8'h34, r); check("R3 locked scratch", r, 32'h0);

        // R7 no counting while run clear
        pulse(PRE);
        rd(8'h04, r); check("R7 stopped", r, 32'hE);

        keyed_wr(8'h00, 32'h2D);
        pulse(PRE - 1);
        rd(8'h04, r); check("R7 one short", r, 32'hE);
        check("R10 irq idle", {31'd0, irq}, 32'd0);
        pulse(1);
        rd(8'h04, r); check("R7 tick", r, 32'hF);
        rd(8'h00, r); check("R9 second event", r, 32'hED);
        check("R10 irq second", {31'd0, irq}, 32'd1);
        pulse(PRE);
        rd(8'h00, r); check("R8 alarm event", r, 32'hFD);

        // R9 write 0 clears, write 1 keeps
        keyed_wr(8'h00, 32'h3D);
        rd(8'h00, r); check("R9 clear second keep alarm", r, 32'hBD);
        check("R10 irq alarm path", {31'd0, irq}, 32'd1);
        keyed_wr(8'h00, 32'h2D);
        rd(8'h00, r); check("R9 clear alarm", r, 32'hAD);
        check("R10 irq cleared", {31'd0, irq}, 32'd0);

        // R10 event without enable
        keyed_wr(8'h00, 32'h05);
        pulse(PRE);
        rd(8'h04, r); check("R7 count", r, 32'h11);
        rd(8'h00, r); check("R9 event masked", r, 32'hC5);
        check("R10 irq masked", {31'd0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule